// File: doc/BRIEF.md
# Full-Search SAD Motion Estimator

This block finds the best match for one square block of pixels inside a larger square search area. It uses exhaustive block matching. Two internal pixel stores are filled through a write stream before a search starts. One store holds the block being matched. The other holds the search area, which is twice the block edge minus one pixel wide and high. A start pulse then launches the search over every candidate placement. The cost of each placement is the sum of absolute differences (SAD) between corresponding pixels.

The search runs in passes, one pass per vertical offset. Within a pass, one processing element per horizontal offset accumulates its SAD. All elements get the same block pixel in the same cycle, and each one reads the area pixel shifted by its own horizontal offset. At the end of a pass:

- a combinational comparator picks the best of the element totals;
- a running tracker keeps the best total seen over all passes.

After the final pass, the smallest SAD and its displacement are offered on a result stream.

Back-pressure rules are as follows:

- The load stream accepts a write only in a cycle where `ld_valid` and `ld_ready` are both high. `ld_ready` is low from the moment a search starts until its result has been taken.
- The result stream holds its data steady while `res_valid` is high and `res_ready` is low.
- The result is consumed in the cycle where `res_valid` and `res_ready` are both high.

Top module: `me_full_search`

## Requirements
- R1: After reset, `busy` and `res_valid` are 0 and `ld_ready` is 1.
- R2: A load write takes effect only on a cycle with `ld_valid` and `ld_ready` both high. `ld_ref`=1 selects the block store and `ld_ref`=0 selects the area store. Both stores are addressed row-major as row*width+column. `ld_ready` is 0 while busy or while a result is pending, and writes offered then change nothing.
- R3: `res_sad` equals the minimum, over all candidate offsets (x,y) with 0 <= x,y < BLK, of the sum over r,c of |block(r,c) - area(y+r, x+c)|.
- R4: `res_mvx` and `res_mvy` are the unsigned horizontal and vertical offsets of the winning candidate. They are measured from the top-left pixel of the area.
- R5: When several candidates share the minimum SAD, the one with the lowest vertical offset wins. Among those, the one with the lowest horizontal offset wins.
- R6: `res_valid` rises exactly BLK*BLK*BLK+1 clock cycles after the edge that accepts `start`.
- R7: A `start` pulse is accepted only while idle (`ld_ready` high). A pulse during a search or while a result is pending neither restarts nor changes the search.
- R8: While `res_valid` is 1 and `res_ready` is 0, the result outputs hold steady. The cycle after `res_valid` and `res_ready` are both 1, the block is idle: `res_valid` is 0 and `ld_ready` is 1.
- R9: `busy` is 1 from the cycle after start acceptance until `res_valid` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load write offered |
| ld_ready | output | 1 | Load write can be taken (block idle) |
| ld_ref | input | 1 | 1 = block store, 0 = area store |
| ld_addr | input | clog2((2*BLK-1)^2) | Row-major pixel address |
| ld_data | input | PIX_W | Pixel value |
| start | input | 1 | Begin a search (single-cycle pulse) |
| busy | output | 1 | Search in progress |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result accepted by consumer |
| res_sad | output | PIX_W+2*clog2(BLK) | Minimum SAD |
| res_mvx | output | clog2(BLK) | Horizontal offset of best match |
| res_mvy | output | clog2(BLK) | Vertical offset of best match |

## Verification
The bench builds the block with its defaults: 8-bit pixels, a 16x16 block and a 31x31 area. This gives 256 candidates, a 16-bit SAD that can reach its largest possible value, and offsets at both ends of their 4-bit range. With these sizes, a planted exact copy can sit deep inside the area. Two identical copies can also be placed so that the vertical-first tie rule is the deciding factor. The long search of 4097 cycles leaves room to push starts and writes against a busy block and to stall the result stream for many cycles.

// File: rtl/me_pkg.sv
package me_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_HOLD  = 2'd3
  } me_state_e;
endpackage

// File: rtl/me_pe.sv
module me_pe #(
  parameter int PIX_W = 8,
  parameter int SAD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [PIX_W-1:0] ref_px,
  input  logic [PIX_W-1:0] win_px,
  output logic [SAD_W-1:0] sad
);
  logic [PIX_W-1:0] diff;

  assign diff = (ref_px > win_px) ? (ref_px - win_px) : (win_px - ref_px);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sad <= '0;
    end else if (en) begin
      if (clr) sad <= SAD_W'(diff);
      else     sad <= sad + SAD_W'(diff);
    end
  end
endmodule

// File: rtl/me_inst_min.sv
module me_inst_min #(
  parameter int N     = 16,
  parameter int SAD_W = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][SAD_W-1:0] sads,
  output logic [SAD_W-1:0]        min_sad,
  output logic [IDX_W-1:0]        min_idx
);
  always_comb begin
    min_sad = sads[0];
    min_idx = '0;
    for (int i = 1; i < N; i++) begin
      if (sads[i] < min_sad) begin
        min_sad = sads[i];
        min_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/me_tracker.sv
module me_tracker #(
  parameter int SAD_W = 16,
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             upd,
  input  logic [SAD_W-1:0] in_sad,
  input  logic [OFF_W-1:0] in_x,
  input  logic [OFF_W-1:0] in_y,
  output logic [SAD_W-1:0] best_sad,
  output logic [OFF_W-1:0] best_x,
  output logic [OFF_W-1:0] best_y
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      best_sad <= '1;
      best_x   <= '0;
      best_y   <= '0;
    end else if (upd && (in_sad < best_sad)) begin
      best_sad <= in_sad;
      best_x   <= in_x;
      best_y   <= in_y;
    end
  end
endmodule

// File: rtl/me_ctrl.sv
module me_ctrl
  import me_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             res_ready,
  output logic             acc_en,
  output logic             acc_clr,
  output logic [OFF_W-1:0] row,
  output logic [OFF_W-1:0] col,
  output logic [OFF_W-1:0] voff,
  output logic             cmp_en,
  output logic [OFF_W-1:0] cmp_v,
  output logic             start_acc,
  output logic             idle,
  output logic             busy,
  output logic             hold
);
  localparam int K_W = 2 * OFF_W;

  me_state_e      state;
  logic [K_W-1:0] k;

  assign row       = k[K_W-1:OFF_W];
  assign col       = k[OFF_W-1:0];
  assign idle      = (state == ST_IDLE);
  assign hold      = (state == ST_HOLD);
  assign busy      = (state == ST_RUN) || (state == ST_FLUSH);
  assign acc_en    = (state == ST_RUN);
  assign acc_clr   = (k == '0);
  assign start_acc = idle && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      k      <= '0;
      voff   <= '0;
      cmp_en <= 1'b0;
      cmp_v  <= '0;
    end else begin
      cmp_en <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            k     <= '0;
            voff  <= '0;
          end
        end
        ST_RUN: begin
          k <= k + 1'b1;
          if (k == '1) begin
            cmp_en <= 1'b1;
            cmp_v  <= voff;
            if (voff == '1) state <= ST_FLUSH;
            else            voff  <= voff + 1'b1;
          end
        end
        ST_FLUSH: state <= ST_HOLD;
        ST_HOLD:  if (res_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/me_full_search.sv
module me_full_search #(
  parameter int PIX_W = 8,
  parameter int BLK   = 16
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      ld_valid,
  output logic                                      ld_ready,
  input  logic                                      ld_ref,
  input  logic [$clog2((2*BLK-1)*(2*BLK-1))-1:0]    ld_addr,
  input  logic [PIX_W-1:0]                          ld_data,
  input  logic                                      start,
  output logic                                      busy,
  output logic                                      res_valid,
  input  logic                                      res_ready,
  output logic [PIX_W+2*$clog2(BLK)-1:0]            res_sad,
  output logic [$clog2(BLK)-1:0]                    res_mvx,
  output logic [$clog2(BLK)-1:0]                    res_mvy
);
  localparam int WIN    = 2 * BLK - 1;
  localparam int OFF_W  = $clog2(BLK);
  localparam int K_W    = 2 * OFF_W;
  localparam int SAD_W  = PIX_W + K_W;
  localparam int ADDR_W = $clog2(WIN * WIN);
  localparam int NREF   = BLK * BLK;
  localparam int NWIN   = WIN * WIN;

  logic [PIX_W-1:0] win_mem [NWIN];
  logic [PIX_W-1:0] ref_mem [NREF];

  logic             acc_en, acc_clr, cmp_en, start_acc, idle, hold;
  logic [OFF_W-1:0] row, col, voff, cmp_v;
  logic [PIX_W-1:0] ref_px;
  logic [BLK-1:0][SAD_W-1:0] pe_sad;
  logic [SAD_W-1:0] inst_sad;
  logic [OFF_W-1:0] inst_x;

  // Pixel stores, written only while idle.
  always_ff @(posedge clk) begin
    if (ld_valid && ld_ready) begin
      if (ld_ref) begin
        if (ld_addr < ADDR_W'(NREF)) ref_mem[ld_addr[K_W-1:0]] <= ld_data;
      end else begin
        if (ld_addr < ADDR_W'(NWIN)) win_mem[ld_addr] <= ld_data;
      end
    end
  end

  me_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .res_ready(res_ready),
    .acc_en(acc_en), .acc_clr(acc_clr), .row(row), .col(col), .voff(voff),
    .cmp_en(cmp_en), .cmp_v(cmp_v), .start_acc(start_acc),
    .idle(idle), .busy(busy), .hold(hold)
  );

  assign ref_px = ref_mem[{row, col}];

  // One element per horizontal offset; the block pixel is broadcast.
  for (genvar h = 0; h < BLK; h++) begin : g_pe
    logic [ADDR_W-1:0] rd_idx;
    assign rd_idx = (ADDR_W'(voff) + ADDR_W'(row)) * ADDR_W'(WIN)
                  + ADDR_W'(col) + ADDR_W'(h);
    me_pe #(.PIX_W(PIX_W), .SAD_W(SAD_W)) u_pe (
      .clk(clk), .rst_n(rst_n), .en(acc_en), .clr(acc_clr),
      .ref_px(ref_px), .win_px(win_mem[rd_idx]), .sad(pe_sad[h])
    );
  end

  me_inst_min #(.N(BLK), .SAD_W(SAD_W)) u_inst (
    .sads(pe_sad), .min_sad(inst_sad), .min_idx(inst_x)
  );

  me_tracker #(.SAD_W(SAD_W), .OFF_W(OFF_W)) u_track (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .upd(cmp_en),
    .in_sad(inst_sad), .in_x(inst_x), .in_y(cmp_v),
    .best_sad(res_sad), .best_x(res_mvx), .best_y(res_mvy)
  );

  assign ld_ready  = idle;
  assign res_valid = hold;
endmodule

// File: rtl/me_full_search_chk.sv
module me_full_search_chk #(
  parameter int PIX_W = 8,
  parameter int BLK   = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           ld_ready,
  input logic                           start,
  input logic                           busy,
  input logic                           res_valid,
  input logic                           res_ready,
  input logic [PIX_W+2*$clog2(BLK)-1:0] res_sad,
  input logic [$clog2(BLK)-1:0]         res_mvx,
  input logic [$clog2(BLK)-1:0]         res_mvy
);
  localparam int LAT     = BLK * BLK * BLK + 1;
  localparam int MAX_SAD = BLK * BLK * ((1 << PIX_W) - 1);

  int unsigned since_start;

  always_ff @(posedge clk) begin
    if (!rst_n)                    since_start <= 0;
    else if (start && ld_ready)    since_start <= 0;
    else if (since_start < 32'hFFFF_FFF0) since_start <= since_start + 1;
  end

  AST_LD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || res_valid) |-> !ld_ready) else $error("ld_ready while occupied"); // R2
  AST_SAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (int'(res_sad) <= MAX_SAD)) else $error("SAD above bound"); // R3
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (since_start == LAT)) else $error("result latency"); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || res_valid)) else $error("search restarted"); // R7
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_sad)
      && $stable(res_mvx) && $stable(res_mvy))) else $error("result moved"); // R8
  AST_RES_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (!res_valid && ld_ready)) else $error("no release"); // R8
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ld_ready) |=> busy) else $error("busy not raised"); // R9
endmodule

bind me_full_search me_full_search_chk #(.PIX_W(PIX_W), .BLK(BLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_ready(ld_ready), .start(start), .busy(busy),
  .res_valid(res_valid), .res_ready(res_ready), .res_sad(res_sad),
  .res_mvx(res_mvx), .res_mvy(res_mvy)
);

// File: tb/me_full_search_test.sv
module me_full_search_test;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W  = 8;
  localparam int BLK    = 16;
  localparam int WIN    = 2 * BLK - 1;
  localparam int ADDR_W = $clog2(WIN * WIN);
  localparam int OFF_W  = $clog2(BLK);
  localparam int SAD_W  = PIX_W + 2 * OFF_W;
  localparam int LAT    = BLK * BLK * BLK + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0, ld_ref = 1'b0, start = 1'b0, res_ready = 1'b1;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [PIX_W-1:0]  ld_data = '0;
  logic ld_ready, busy, res_valid;
  logic [SAD_W-1:0] res_sad;
  logic [OFF_W-1:0] res_mvx, res_mvy;

  always #(CLK_PERIOD/2) clk = ~clk;

  me_full_search #(.PIX_W(PIX_W), .BLK(BLK)) uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_ref(ld_ref), .ld_addr(ld_addr), .ld_data(ld_data), .start(start),
    .busy(busy), .res_valid(res_valid), .res_ready(res_ready),
    .res_sad(res_sad), .res_mvx(res_mvx), .res_mvy(res_mvy)
  );

  typedef struct { int sad; int x; int y; } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int errors = 0;
  int win_m [WIN*WIN];
  int ref_m [BLK*BLK];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Scoreboard monitor: compare each accepted result with the queue head.
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected result", int'(res_sad), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(res_sad) == e.sad, "R3 sad", int'(res_sad), e.sad);
        check(int'(res_mvx) == e.x, "R4/R5 mvx", int'(res_mvx), e.x);
        check(int'(res_mvy) == e.y, "R4/R5 mvy", int'(res_mvy), e.y);
      end
    end
  end

  task automatic load_all();
    for (int i = 0; i < WIN*WIN; i++) begin
      ld_valid = 1'b1; ld_ref = 1'b0; ld_addr = ADDR_W'(i); ld_data = PIX_W'(win_m[i]);
      tick();
    end
    for (int i = 0; i < BLK*BLK; i++) begin
      ld_valid = 1'b1; ld_ref = 1'b1; ld_addr = ADDR_W'(i); ld_data = PIX_W'(ref_m[i]);
      tick();
    end
    ld_valid = 1'b0;
  endtask

  // Driver: compute expected result from the model and queue it.
  task automatic push_expected(output exp_t e);
    e.sad = 32'h7fffffff; e.x = 0; e.y = 0;
    for (int y = 0; y < BLK; y++) begin
      for (int x = 0; x < BLK; x++) begin
        int s;
        s = 0;
        for (int r = 0; r < BLK; r++)
          for (int c = 0; c < BLK; c++) begin
            int d;
            d = ref_m[r*BLK+c] - win_m[(y+r)*WIN + x + c];
            s += (d < 0) ? -d : d;
          end
        if (s < e.sad) begin e.sad = s; e.x = x; e.y = y; end
      end
    end
    exp_q.push_back(e);
  endtask

  // Start a search; when poke is set, push start and writes against the busy block.
  task automatic run_search(input bit poke, input int stall);
    exp_t e;
    int cnt;
    push_expected(e);
    start = 1'b1;
    tick();
    start = 1'b0;
    cnt = 0;
    while (!res_valid && cnt < LAT + 10) begin
      if (poke && cnt == 100) begin
        start = 1'b1; ld_valid = 1'b1; ld_ref = 1'b1; ld_addr = '0;
        ld_data = PIX_W'(ref_m[0] ^ 8'h5A);
        check(ld_ready == 1'b0, "R2 ld_ready low while busy", int'(ld_ready), 0);
        check(busy == 1'b1, "R9 busy during search", int'(busy), 1);
      end
      if (poke && cnt == 104) begin start = 1'b0; ld_valid = 1'b0; end
      tick();
      cnt++;
    end
    check(cnt == LAT, "R6 latency", cnt, LAT);
    check(busy == 1'b0, "R9 busy low with result", int'(busy), 0);
    if (stall > 0) begin
      logic [SAD_W-1:0] s0;
      logic [OFF_W-1:0] x0, y0;
      s0 = res_sad; x0 = res_mvx; y0 = res_mvy;
      for (int i = 0; i < stall; i++) begin
        if (i == 5) start = 1'b1;
        if (i == 6) start = 1'b0;
        tick();
      end
      check(res_valid == 1'b1, "R8 valid held", int'(res_valid), 1);
      check(res_sad == s0 && res_mvx == x0 && res_mvy == y0, "R8 data held",
            int'(res_sad), int'(s0));
      check(ld_ready == 1'b0, "R7 start ignored while pending", int'(ld_ready), 0);
      res_ready = 1'b1;
    end
    tick();
    check(res_valid == 1'b0, "R8 released", int'(res_valid), 0);
    check(ld_ready == 1'b1, "R8 idle after accept", int'(ld_ready), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(res_valid == 1'b0, "R1 res_valid after reset", int'(res_valid), 0);
    check(ld_ready == 1'b1, "R1 ld_ready after reset", int'(ld_ready), 1);

    // Random area and block (R3, R4).
    for (int i = 0; i < WIN*WIN; i++) win_m[i] = int'($urandom_range(0, 255));
    for (int i = 0; i < BLK*BLK; i++) ref_m[i] = int'($urandom_range(0, 255));
    load_all();
    run_search(1'b0, 0);

    // Exact copy planted at x=11, y=5 (R3, R4).
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++) win_m[(5+r)*WIN + 11 + c] = ref_m[r*BLK+c];
    load_all();
    run_search(1'b0, 0);
    check(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);

    // Tie: constant copies at (3,9) and (12,2); vertical-first picks (12,2) (R5).
    for (int i = 0; i < WIN*WIN; i++) win_m[i] = int'($urandom_range(0, 50));
    for (int i = 0; i < BLK*BLK; i++) ref_m[i] = 200;
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++) begin
        win_m[(9+r)*WIN + 3 + c]  = 200;
        win_m[(2+r)*WIN + 12 + c] = 200;
      end
    load_all();
    run_search(1'b0, 0);
    check(int'(res_mvx) == 12 && int'(res_mvy) == 2, "R5 tie picks lower y",
          int'(res_mvy), 2);

    // Largest SAD, all candidates tie at 65280: offsets (0,0) (R3, R5).
    for (int i = 0; i < WIN*WIN; i++) win_m[i] = 0;
    for (int i = 0; i < BLK*BLK; i++) ref_m[i] = 255;
    load_all();
    run_search(1'b0, 0);
    check(int'(res_sad) == BLK*BLK*255, "R3 maximum sad", int'(res_sad), BLK*BLK*255);

    // Corner copy at x=15, y=15 with starts and writes pushed while busy (R2, R7).
    for (int i = 0; i < WIN*WIN; i++) win_m[i] = int'($urandom_range(0, 255));
    for (int i = 0; i < BLK*BLK; i++) ref_m[i] = int'($urandom_range(0, 255));
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++) win_m[(15+r)*WIN + 15 + c] = ref_m[r*BLK+c];
    load_all();
    run_search(1'b1, 0);
    // Same stores, no reload: the blocked write must have changed nothing (R2).
    res_ready = 1'b0;
    run_search(1'b0, 20);
    check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule